// File: doc/BRIEF.md
# Monochrome Raster Scanout with Row Tripling

This block produces the sync and pixel stream for an 800x600, 56 Hz monitor mode, clocked from a 72 MHz system clock. Each scan line takes 2048 clocks and each frame takes 625 lines. Free-running horizontal and vertical counters drive the two sync outputs. The same counters open the window in which pixels are sent.

The image comes from an external frame buffer holding one bit per pixel, eight pixels to a byte. The buffer has a synchronous, byte-wide read port. On every visible line the block reads one buffer row, a byte at a time. Each byte is sent out most significant bit first, and every pixel is held for a fixed number of clocks. Each buffer row is shown on three scan lines in a row, so a buffer with one third of the screen's lines fills the whole visible height. When the last row has been shown, drawing stops. It starts again at row zero once the next frame's vertical back porch has ended.

All timing values are parameters. The defaults give the full-size mode. A reduced set keeps the same structure and gives a short frame.

Top module: `monoScanout`

## Requirements
- R1: While reset is high, and at the first clock after it is released, the counters stand at line 0, tick 0. So `hsyncN` is low, `vsync` is high, `pixel` is low and `memRdEn` is low.
- R2: A scan line is LINE_TICKS clocks long. `hsyncN` is low (active) for the first HSYNC_TICKS clocks of every line and high for the rest.
- R3: A frame is FRAME_LINES lines long. `vsync` is high (active) for the first VSYNC_LINES lines of each frame and low for the rest. It changes only at the first tick of a line.
- R4: On a drawing line, the first pixel appears at tick PIX_START. Each pixel lasts CLKS_PER_PIX clocks. BYTES_PER_ROW bytes are sent from consecutive buffer addresses, bit 7 of each byte first.
- R5: `pixel` is low on every line before line DRAW_START_LINE, and on every tick outside the pixel window of a drawing line.
- R6: Each buffer row is shown on ROW_REPEAT consecutive lines, using the same addresses each time. After that, the row's start address moves up by BYTES_PER_ROW.
- R7: After BUF_ROWS rows have been shown, `pixel` stays low and no read is issued until line DRAW_START_LINE of the next frame. That frame starts again at address 0.
- R8: A read for byte k is issued exactly two clocks before that byte's first pixel, and data is taken one clock after the read. Reads happen only on drawing lines, and every address is below BUF_ROWS*BYTES_PER_ROW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |
| pixel | output | 1 | Serial monochrome pixel |
| memRdEn | output | 1 | Frame-buffer read strobe |
| memAddr | output | ADDR_W | Frame-buffer byte address, ADDR_W = clog2(BUF_ROWS*BYTES_PER_ROW) |
| memData | input | 8 | Read data, valid the clock after `memRdEn` |

## Verification
The assertions rely on reset being held for at least one clock, and on the memory answering every read exactly one clock later. They also assume a parameter set in which the whole pixel window fits inside one line, all drawing lines fit inside one frame, PIX_START is at least 2 and CLKS_PER_PIX is at least 2. The bench uses a reduced parameter set that keeps all of these relations: a 128-clock line, a 20-line frame, and four rows of three bytes. Its memory model returns a new byte only in the clock after a read. The byte pattern changes between frames, so each frame checks the shifting against different data.

// File: rtl/monoScanoutPkg.sv
package monoScanoutPkg;
  typedef struct packed {
    logic rdFirst;  // read byte 0 of the current row
    logic rdNext;   // read the byte after the last one read
    logic load;     // move read data into the shifter
    logic shift;    // step the shifter by one pixel
    logic pixOn;    // pixel window open
    logic rowAdv;   // move to the next buffer row
    logic rowClr;   // return to buffer row 0
  } scanStrobes_t;
endpackage

// File: rtl/monoScanCtrl.sv
module monoScanCtrl
  import monoScanoutPkg::*;
#(
  parameter int LINE_TICKS      = 2048,
  parameter int HSYNC_TICKS     = 144,
  parameter int PIX_START       = 352,
  parameter int BYTES_PER_ROW   = 52,
  parameter int CLKS_PER_PIX    = 4,
  parameter int FRAME_LINES     = 625,
  parameter int VSYNC_LINES     = 2,
  parameter int DRAW_START_LINE = 24,
  parameter int ROW_REPEAT      = 3,
  parameter int BUF_ROWS        = 200
) (
  input  logic         clk,
  input  logic         rst,
  output logic         hsyncN,
  output logic         vsync,
  output scanStrobes_t strb
);
  localparam int HW  = $clog2(LINE_TICKS);
  localparam int VW  = $clog2(FRAME_LINES);
  localparam int RPW = $clog2(ROW_REPEAT + 1);
  localparam int RW  = $clog2(BUF_ROWS + 1);
  localparam int PHW = (CLKS_PER_PIX > 1) ? $clog2(CLKS_PER_PIX) : 1;
  localparam int BYW = $clog2(BYTES_PER_ROW + 1);

  logic [HW-1:0]  hCnt;
  logic [VW-1:0]  vCnt;
  logic           drawEn;
  logic [RPW-1:0] repCnt;
  logic [RW-1:0]  rowIdx;
  logic           busy;
  logic [PHW-1:0] phase;
  logic [2:0]     bitNo;
  logic [BYW-1:0] byteNo;

  logic lineEnd, frameEnd, startRead, startLoad, pixelEnd, byteEnd, lastByte;
  logic lastRep, lastRow;

  assign lineEnd   = (hCnt == HW'(LINE_TICKS - 1));
  assign frameEnd  = (vCnt == VW'(FRAME_LINES - 1));
  assign startRead = drawEn && (hCnt == HW'(PIX_START - 2));
  assign startLoad = drawEn && (hCnt == HW'(PIX_START - 1));
  assign pixelEnd  = busy && (phase == PHW'(CLKS_PER_PIX - 1));
  assign byteEnd   = pixelEnd && (bitNo == 3'd7);
  assign lastByte  = (byteNo == BYW'(BYTES_PER_ROW - 1));
  assign lastRep   = (repCnt == RPW'(ROW_REPEAT - 1));
  assign lastRow   = (rowIdx == RW'(BUF_ROWS - 1));

  // raster counters
  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + 1'b1;
      if (lineEnd) vCnt <= frameEnd ? '0 : vCnt + 1'b1;
    end
  end

  // draw enable and row repetition
  always_ff @(posedge clk) begin
    if (rst) begin
      drawEn <= 1'b0;
      repCnt <= '0;
      rowIdx <= '0;
    end else if (lineEnd) begin
      if (drawEn) begin
        if (lastRep) begin
          repCnt <= '0;
          if (lastRow) begin
            rowIdx <= '0;
            drawEn <= 1'b0;
          end else begin
            rowIdx <= rowIdx + 1'b1;
          end
        end else begin
          repCnt <= repCnt + 1'b1;
        end
      end else if (vCnt == VW'(DRAW_START_LINE - 1)) begin
        drawEn <= 1'b1;
      end
    end
  end

  // serializer timing: pixel phase, bit and byte position in the window
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      phase  <= '0;
      bitNo  <= '0;
      byteNo <= '0;
    end else if (startLoad) begin
      busy   <= 1'b1;
      phase  <= '0;
      bitNo  <= '0;
      byteNo <= '0;
    end else if (busy) begin
      phase <= pixelEnd ? '0 : phase + 1'b1;
      if (pixelEnd) bitNo <= bitNo + 1'b1;
      if (byteEnd) begin
        if (lastByte) busy <= 1'b0;
        else          byteNo <= byteNo + 1'b1;
      end
    end
  end

  assign hsyncN = (hCnt >= HW'(HSYNC_TICKS));
  assign vsync  = (vCnt < VW'(VSYNC_LINES));

  always_comb begin
    strb.rdFirst = startRead;
    strb.rdNext  = busy && (bitNo == 3'd7) && (phase == PHW'(CLKS_PER_PIX - 2)) && !lastByte;
    strb.load    = startLoad || (byteEnd && !lastByte);
    strb.shift   = pixelEnd && !byteEnd;
    strb.pixOn   = busy;
    strb.rowAdv  = lineEnd && drawEn && lastRep;
    strb.rowClr  = lineEnd && drawEn && lastRep && lastRow;
  end
endmodule

// File: rtl/monoScanData.sv
module monoScanData
  import monoScanoutPkg::*;
#(
  parameter int BYTES_PER_ROW = 52,
  parameter int BUF_ROWS      = 200,
  parameter int ADDR_W        = $clog2(BUF_ROWS * BYTES_PER_ROW)
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobes_t      strb,
  input  logic [7:0]        memData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixel
);
  logic [ADDR_W-1:0] rowBase;
  logic [ADDR_W-1:0] lastAddr;
  logic [7:0]        shiftReg;

  assign memRdEn = strb.rdFirst | strb.rdNext;
  assign memAddr = strb.rdFirst ? rowBase : lastAddr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rowBase  <= '0;
      lastAddr <= '0;
      shiftReg <= '0;
    end else begin
      if (strb.rowClr)      rowBase <= '0;
      else if (strb.rowAdv) rowBase <= rowBase + ADDR_W'(BYTES_PER_ROW);
      if (memRdEn) lastAddr <= memAddr;
      if (strb.load)       shiftReg <= memData;
      else if (strb.shift) shiftReg <= {shiftReg[6:0], 1'b0};
    end
  end

  assign pixel = strb.pixOn & shiftReg[7];
endmodule

// File: rtl/monoScanout.sv
module monoScanout
  import monoScanoutPkg::*;
#(
  parameter int LINE_TICKS      = 2048,
  parameter int HSYNC_TICKS     = 144,
  parameter int PIX_START       = 352,
  parameter int BYTES_PER_ROW   = 52,
  parameter int CLKS_PER_PIX    = 4,
  parameter int FRAME_LINES     = 625,
  parameter int VSYNC_LINES     = 2,
  parameter int DRAW_START_LINE = 24,
  parameter int ROW_REPEAT      = 3,
  parameter int BUF_ROWS        = 200,
  localparam int ADDR_W         = $clog2(BUF_ROWS * BYTES_PER_ROW)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              hsyncN,
  output logic              vsync,
  output logic              pixel,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData
);
  scanStrobes_t strb;

  monoScanCtrl #(
    .LINE_TICKS(LINE_TICKS), .HSYNC_TICKS(HSYNC_TICKS), .PIX_START(PIX_START),
    .BYTES_PER_ROW(BYTES_PER_ROW), .CLKS_PER_PIX(CLKS_PER_PIX),
    .FRAME_LINES(FRAME_LINES), .VSYNC_LINES(VSYNC_LINES),
    .DRAW_START_LINE(DRAW_START_LINE), .ROW_REPEAT(ROW_REPEAT), .BUF_ROWS(BUF_ROWS)
  ) ctrl (
    .clk(clk), .rst(rst), .hsyncN(hsyncN), .vsync(vsync), .strb(strb)
  );

  monoScanData #(
    .BYTES_PER_ROW(BYTES_PER_ROW), .BUF_ROWS(BUF_ROWS), .ADDR_W(ADDR_W)
  ) data (
    .clk(clk), .rst(rst), .strb(strb), .memData(memData),
    .memRdEn(memRdEn), .memAddr(memAddr), .pixel(pixel)
  );
endmodule

// File: rtl/monoScanoutChk.sv
module monoScanoutChk #(
  parameter int LINE_TICKS    = 2048,
  parameter int HSYNC_TICKS   = 144,
  parameter int BYTES_PER_ROW = 52,
  parameter int BUF_ROWS      = 200,
  parameter int ADDR_W        = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              hsyncN,
  input logic              vsync,
  input logic              pixel,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr
);
  localparam int LW = $clog2(LINE_TICKS + 1);
  logic [LW-1:0] lowRun;

  always_ff @(posedge clk) begin
    if (rst)          lowRun <= '0;
    else if (!hsyncN) lowRun <= lowRun + 1'b1;
    else              lowRun <= '0;
  end

  // R2: each sync pulse is exactly HSYNC_TICKS clocks wide
  p_hsync_width_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hsyncN) |-> (lowRun == LW'(HSYNC_TICKS)));

  // R3: vertical sync moves only at the start of a line
  p_vsync_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(vsync) |-> $fell(hsyncN));

  // R5: no lit pixel during either sync interval
  p_pix_blank_sync_r5: assert property (@(posedge clk) disable iff (rst)
    pixel |-> (hsyncN && !vsync));

  // R8: reads stay inside the buffer
  p_addr_range_r8: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> (int'(memAddr) < BUF_ROWS * BYTES_PER_ROW));

  // R8: reads only in the visible part of a line
  p_read_in_view_r8: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> (hsyncN && !vsync));
endmodule

bind monoScanout monoScanoutChk #(
  .LINE_TICKS(LINE_TICKS), .HSYNC_TICKS(HSYNC_TICKS),
  .BYTES_PER_ROW(BYTES_PER_ROW), .BUF_ROWS(BUF_ROWS), .ADDR_W(ADDR_W)
) chk (
  .clk(clk), .rst(rst), .hsyncN(hsyncN), .vsync(vsync), .pixel(pixel),
  .memRdEn(memRdEn), .memAddr(memAddr)
);

// File: tb/monoScanout_test.sv
module monoScanout_test;
  localparam int LT  = 128;  // line ticks
  localparam int HS  = 8;
  localparam int PS  = 20;
  localparam int BPR = 3;
  localparam int CPP = 4;
  localparam int FL  = 20;
  localparam int VS  = 2;
  localparam int DSL = 4;
  localparam int REP = 3;
  localparam int ROWS = 4;
  localparam int AW  = $clog2(ROWS * BPR);
  localparam int FT  = LT * FL;
  localparam int BT  = 8 * CPP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsyncN, vsync, pixel, memRdEn;
  logic [AW-1:0] memAddr;
  logic [7:0] memData = 8'h00;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  monoScanout #(
    .LINE_TICKS(LT), .HSYNC_TICKS(HS), .PIX_START(PS), .BYTES_PER_ROW(BPR),
    .CLKS_PER_PIX(CPP), .FRAME_LINES(FL), .VSYNC_LINES(VS),
    .DRAW_START_LINE(DSL), .ROW_REPEAT(REP), .BUF_ROWS(ROWS)
  ) uut (
    .clk(clk), .rst(rst), .hsyncN(hsyncN), .vsync(vsync), .pixel(pixel),
    .memRdEn(memRdEn), .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [7:0] patByte(input int a, input int fr);
    case (fr % 3)
      0:       return 8'(a * 29 + 91) ^ 8'(a >> 2);
      1:       return 8'hF0 ^ 8'(a);
      default: return 8'(a << 3) | 8'h01;
    endcase
  endfunction

  // frame-buffer model: synchronous read, one clock latency
  always @(posedge clk) if (memRdEn) memData <= patByte(int'(memAddr), n / FT);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, n);
    end
  endtask

  // behavioural reference for cycle index k after reset release
  task automatic checkCycle(input int k);
    int h = k % LT;
    int v = (k / LT) % FL;
    int fr = k / FT;
    bit drawLine = (v >= DSL) && (v < DSL + ROWS * REP);
    int row = drawLine ? (v - DSL) / REP : 0;
    int rep = drawLine ? (v - DSL) % REP : 0;
    int expPix = 0;
    int expRd = 0;
    int expAddr = -1;
    string pTag;
    chk("R2", "hsyncN", int'(hsyncN), (h >= HS) ? 1 : 0);
    chk("R3", "vsync", int'(vsync), (v < VS) ? 1 : 0);
    if (drawLine && h >= PS && h < PS + BPR * BT) begin
      int i = (h - PS) / CPP;
      logic [7:0] b = patByte(row * BPR + i / 8, fr);
      expPix = int'(b[7 - i % 8]);
      pTag = (row > 0 || rep > 0) ? "R6" : "R4";
    end else if (v >= DSL + ROWS * REP) begin
      pTag = "R7";
    end else begin
      pTag = "R5";
    end
    chk(pTag, "pixel", int'(pixel), expPix);
    if (drawLine && h >= PS - 2 && (h - (PS - 2)) % BT == 0 && (h - (PS - 2)) / BT < BPR) begin
      expRd = 1;
      expAddr = row * BPR + (h - (PS - 2)) / BT;
    end
    chk(drawLine ? "R8" : "R7", "memRdEn", int'(memRdEn), expRd);
    if (expRd == 1 && memRdEn)
      chk((fr > 0 && row == 0) ? "R7" : "R6", "memAddr", int'(memAddr), expAddr);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R1", "hsyncN in reset", int'(hsyncN), 0);
      chk("R1", "vsync in reset", int'(vsync), 1);
      chk("R1", "pixel in reset", int'(pixel), 0);
      chk("R1", "memRdEn in reset", int'(memRdEn), 0);
    end
    @(negedge clk);
    n = 0;
    checkCycle(0);
    rst = 1'b0;
    @(negedge clk);
    n = 1;
    chk("R1", "hsyncN after release", int'(hsyncN), 0);
    chk("R1", "vsync after release", int'(vsync), 1);
    checkCycle(1);
    for (int k = 2; k < 3 * FT + LT; k++) begin
      @(negedge clk);
      n = k;
      checkCycle(k);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", n);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule